// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits behind the write port of a 16-bit parallel flash controller. It watches every accepted write cycle, made of a full word address and a data word, and follows the keyed handshake that a host must perform before the flash will alter its contents or change its read source. The key is two cycles: byte AAh at low address 5555h, then byte 55h at low address 2AAAh. A command byte at 5555h follows. Program takes one more cycle, which carries the target address and data. Erase first repeats the two key cycles and then takes a final selector cycle.

Each recognised command leaves the block as a single-clock strobe, together with the captured program address and data or the aligned erase base address. A small mode register picks the read source for the rest of the controller: the array, the identification words, or the query words. A lookup returns the word that belongs to the current mode and read address. A cycle that breaks a sequence throws the partial sequence away and falls back to array reads. While the downstream engine reports an internal program or erase in progress, every write is ignored.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode_o` is 0 (array read), every strobe is low and `tbl_active` is low.
- R2: Key cycles compare only address bits 14..0 and data bits 7..0. The first key is AAh at 5555h and the second is 55h at 2AAAh. Address bits 19..15 and data bits 15..8 have no effect on the match.
- R3: Two key cycles followed by A0h at 5555h make the next write a program write. That write may use any address and data, including key values. On the clock after it is sampled, `prog_stb` is high for one cycle, and `prog_addr` and `prog_data` hold that write's full address and data.
- R4: Two key cycles, then 80h at 5555h, then AAh at 5555h and 55h at 2AAAh, lead to a final cycle that selects the erase. 10h at 5555h gives `chip_erase_stb` with `erase_base` 0. 30h at any address gives `sect_erase_stb` with `erase_base` equal to that address with bits 10..0 cleared. 50h at any address gives `blk_erase_stb` with bits 14..0 cleared.
- R5: Two key cycles followed by 90h at 5555h pulse `id_enter_stb`. Two key cycles followed by 98h at 5555h pulse `cfi_enter_stb`. On the clock after the strobe, `mode_o` becomes 1 (identification) or 2 (query) respectively.
- R6: Exit has two forms, both pulsing `mode_exit_stb` and returning `mode_o` to 0 on the following clock. One form is two key cycles followed by F0h at 5555h. The other is a single F0h write to any address while no sequence is in progress.
- R7: A write that does not match the step expected within a sequence ends it without any strobe and returns `mode_o` to 0. Such writes include a wrong key, an unknown command byte and a bad erase selector. The next write is then treated as a first key cycle.
- R8: While `busy` is high, writes produce no strobe and leave both `mode_o` and the sequence progress unchanged. This includes a single F0h write.
- R9: In mode 1, `tbl_active` is high. `tbl_data` returns 00BFh at read address 0, 2782h at read address 1 and 0000h at any other address.
- R10: In mode 2, `tbl_data` returns 0051h, 0052h and 0059h at read addresses 10h, 11h and 12h, and 0000h at any other address.
- R11: In mode 0, `tbl_active` is low and `tbl_data` is 0000h.
- R12: At most one strobe is high in any cycle, and a strobe only follows a write sampled on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A write cycle is presented this clock |
| wr_addr | input | 20 | Write word address |
| wr_data | input | 16 | Write data word |
| busy | input | 1 | Internal program or erase in progress |
| rd_addr | input | 20 | Read address for the ID/query lookup |
| prog_stb | output | 1 | Program command strobe |
| prog_addr | output | 20 | Captured program address |
| prog_data | output | 16 | Captured program data |
| sect_erase_stb | output | 1 | Sector erase strobe |
| blk_erase_stb | output | 1 | Block erase strobe |
| chip_erase_stb | output | 1 | Chip erase strobe |
| erase_base | output | 20 | Aligned base address of the erase |
| id_enter_stb | output | 1 | Identification mode entry strobe |
| cfi_enter_stb | output | 1 | Query mode entry strobe |
| mode_exit_stb | output | 1 | Return-to-array-read strobe |
| mode_o | output | 2 | Read source: 0 array, 1 identification, 2 query |
| tbl_active | output | 1 | Lookup word replaces array data |
| tbl_data | output | 16 | Lookup word for rd_addr |

## Verification
A sequencer stuck at the wrong step shows up at the latest on the closing write of the next sequence. That write then either pulses the wrong strobe, pulses nothing, or pulses where nothing was due. The scoreboard flags each case on the clock after that write. A mode register that misses an event, or reacts to an event it should ignore, corrupts `tbl_active` and `tbl_data` two clocks after the offending write. The bench probes this after every entry, exit, abort and busy-phase write. Writes issued while `busy` is high, and writes right after an abort, are followed by a full valid sequence, so hidden progress left in the sequencer surfaces as a wrong or missing strobe.

// File: rtl/flash_cmd_pkg.sv
// Shared constants and types for the flash command decoder.
// Assumes a 16-bit data bus whose command byte sits in bits 7..0.
package flash_cmd_pkg;

    localparam int KEY_W = 15;

    localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [7:0]       KEY_BYTE_A = 8'hAA;
    localparam logic [7:0]       KEY_BYTE_B = 8'h55;

    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_ID_ENTER = 8'h90;
    localparam logic [7:0] OP_QRY_ENTER = 8'h98;
    localparam logic [7:0] OP_LEAVE    = 8'hF0;
    localparam logic [7:0] OP_ERASE    = 8'h80;
    localparam logic [7:0] SEL_CHIP    = 8'h10;
    localparam logic [7:0] SEL_SECTOR  = 8'h30;
    localparam logic [7:0] SEL_BLOCK   = 8'h50;

    typedef enum logic [1:0] {
        RD_ARRAY = 2'd0,
        RD_IDENT = 2'd1,
        RD_QUERY = 2'd2
    } rd_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PROG,
        ST_EKEY0,
        ST_EKEY1,
        ST_ESEL
    } seq_state_e;

    typedef struct packed {
        logic prog;
        logic sect;
        logic blk;
        logic chip;
        logic ident;
        logic query;
        logic leave;
    } cmd_pulse_t;

endpackage

// File: rtl/cmd_seq_tracker.sv
// Follows the keyed write handshake and emits one-clock command pulses.
// Assumes wr_valid marks one write per clock; busy locks out every write.
module cmd_seq_tracker
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 11,
    parameter int BLK_LSB  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output cmd_pulse_t        pulse_o,
    output logic              abort_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [DATA_W-1:0] prog_data_o,
    output logic [ADDR_W-1:0] erase_base_o
);

    localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_LSB;
    localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_LSB;

    seq_state_e        state_q, state_d;
    cmd_pulse_t        pulse_d;
    logic              abort_d;
    logic [ADDR_W-1:0] ebase_d;
    logic              accept;
    logic [KEY_W-1:0]  key_addr;
    logic [7:0]        key_byte;
    logic              at_a, at_b;

    assign accept   = wr_valid && !busy;
    assign key_addr = wr_addr[KEY_W-1:0];
    assign key_byte = wr_data[7:0];
    assign at_a     = (key_addr == KEY_ADDR_A);
    assign at_b     = (key_addr == KEY_ADDR_B);

    // Next step, pulse and abort decision for the write presented now.
    always_comb begin
        state_d = state_q;
        pulse_d = '0;
        abort_d = 1'b0;
        ebase_d = '0;
        if (accept) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (at_a && key_byte == KEY_BYTE_A) state_d = ST_KEY1;
                    else if (key_byte == OP_LEAVE)      pulse_d.leave = 1'b1;
                end
                ST_KEY1: begin
                    if (at_b && key_byte == KEY_BYTE_B) state_d = ST_KEY2;
                    else                                abort_d = 1'b1;
                end
                ST_KEY2: begin
                    state_d = ST_IDLE;
                    if (!at_a)                          abort_d = 1'b1;
                    else if (key_byte == OP_PROGRAM)    state_d = ST_PROG;
                    else if (key_byte == OP_ERASE)      state_d = ST_EKEY0;
                    else if (key_byte == OP_ID_ENTER)   pulse_d.ident = 1'b1;
                    else if (key_byte == OP_QRY_ENTER)  pulse_d.query = 1'b1;
                    else if (key_byte == OP_LEAVE)      pulse_d.leave = 1'b1;
                    else                                abort_d = 1'b1;
                end
                ST_PROG: begin
                    state_d      = ST_IDLE;
                    pulse_d.prog = 1'b1;
                end
                ST_EKEY0: begin
                    if (at_a && key_byte == KEY_BYTE_A) state_d = ST_EKEY1;
                    else                                abort_d = 1'b1;
                end
                ST_EKEY1: begin
                    if (at_b && key_byte == KEY_BYTE_B) state_d = ST_ESEL;
                    else                                abort_d = 1'b1;
                end
                ST_ESEL: begin
                    state_d = ST_IDLE;
                    if (at_a && key_byte == SEL_CHIP) begin
                        pulse_d.chip = 1'b1;
                    end else if (key_byte == SEL_SECTOR) begin
                        pulse_d.sect = 1'b1;
                        ebase_d      = wr_addr & SECT_MASK;
                    end else if (key_byte == SEL_BLOCK) begin
                        pulse_d.blk = 1'b1;
                        ebase_d     = wr_addr & BLK_MASK;
                    end else begin
                        abort_d = 1'b1;
                    end
                end
                default: abort_d = 1'b1;
            endcase
            if (abort_d) state_d = ST_IDLE;
        end
    end

    // Step register plus registered pulses and abort flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pulse_o <= '0;
            abort_o <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_o <= pulse_d;
            abort_o <= abort_d;
        end
    end

    // Capture of the program word and of the erase base address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_addr_o  <= '0;
            prog_data_o  <= '0;
            erase_base_o <= '0;
        end else begin
            if (pulse_d.prog) begin
                prog_addr_o <= wr_addr;
                prog_data_o <= wr_data;
            end
            if (pulse_d.chip || pulse_d.sect || pulse_d.blk) begin
                erase_base_o <= ebase_d;
            end
        end
    end

    p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_valid) |=> (pulse_o == '0 && !abort_o));

    p_no_write_no_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> (pulse_o == '0 && !abort_o));

endmodule

// File: rtl/cmd_mode_reg.sv
// Holds the read source selected by entry, exit and abort events.
// Assumes at most one event per clock from the sequence tracker.
module cmd_mode_reg
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cmd_pulse_t pulse_i,
    input  logic       abort_i,
    output rd_mode_e   mode_o
);

    // Mode update: entries set their mode, exit and abort restore array read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= RD_ARRAY;
        end else if (pulse_i.ident) begin
            mode_o <= RD_IDENT;
        end else if (pulse_i.query) begin
            mode_o <= RD_QUERY;
        end else if (pulse_i.leave || abort_i) begin
            mode_o <= RD_ARRAY;
        end
    end

    p_mode_event_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_i.ident && !pulse_i.query && !pulse_i.leave && !abort_i)
        |=> $stable(mode_o));

endmodule

// File: rtl/cmd_info_table.sv
// Returns identification or query words for a read address in those modes.
// Assumes rd_addr is a full word address; upper bits must be zero to hit.
module cmd_info_table
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W   = 20,
    parameter int          DATA_W   = 16,
    parameter logic [15:0] MFR_WORD = 16'h00BF,
    parameter logic [15:0] DEV_WORD = 16'h2782,
    parameter int          QRY_BASE = 16
) (
    input  rd_mode_e          mode_i,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              tbl_active,
    output logic [DATA_W-1:0] tbl_data
);

    localparam int QRY_N = 3;

    function automatic logic [7:0] qry_char(input int idx);
        case (idx)
            0:       qry_char = 8'h51;
            1:       qry_char = 8'h52;
            default: qry_char = 8'h59;
        endcase
    endfunction

    logic [QRY_N-1:0]  qry_hit;
    logic [DATA_W-1:0] qry_word [QRY_N];
    logic [DATA_W-1:0] qry_data;
    logic [DATA_W-1:0] id_data;

    for (genvar g = 0; g < QRY_N; g++) begin : g_qry
        assign qry_hit[g]  = (rd_addr == ADDR_W'(QRY_BASE + g));
        assign qry_word[g] = DATA_W'(qry_char(g));
    end

    // Merge of the query words selected by the address.
    always_comb begin
        qry_data = '0;
        for (int i = 0; i < QRY_N; i++) begin
            if (qry_hit[i]) qry_data = qry_word[i];
        end
    end

    // Identification words at addresses 0 and 1.
    always_comb begin
        if (rd_addr == ADDR_W'(0))      id_data = DATA_W'(MFR_WORD);
        else if (rd_addr == ADDR_W'(1)) id_data = DATA_W'(DEV_WORD);
        else                            id_data = '0;
    end

    // Output select by current mode.
    always_comb begin
        unique case (mode_i)
            RD_IDENT: begin tbl_active = 1'b1; tbl_data = id_data;  end
            RD_QUERY: begin tbl_active = 1'b1; tbl_data = qry_data; end
            default:  begin tbl_active = 1'b0; tbl_data = '0;       end
        endcase
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the command decoder: sequence tracker, mode register, lookup.
// Assumes synchronous writes qualified by wr_valid and a busy flag from
// the program/erase engine.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 11,
    parameter int BLK_LSB  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prog_stb,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              sect_erase_stb,
    output logic              blk_erase_stb,
    output logic              chip_erase_stb,
    output logic [ADDR_W-1:0] erase_base,
    output logic              id_enter_stb,
    output logic              cfi_enter_stb,
    output logic              mode_exit_stb,
    output logic [1:0]        mode_o,
    output logic              tbl_active,
    output logic [DATA_W-1:0] tbl_data
);

    cmd_pulse_t pulse;
    logic       abort;
    rd_mode_e   mode;

    cmd_seq_tracker #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SECT_LSB(SECT_LSB),
        .BLK_LSB (BLK_LSB)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .busy        (busy),
        .pulse_o     (pulse),
        .abort_o     (abort),
        .prog_addr_o (prog_addr),
        .prog_data_o (prog_data),
        .erase_base_o(erase_base)
    );

    cmd_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .pulse_i(pulse),
        .abort_i(abort),
        .mode_o (mode)
    );

    cmd_info_table #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_tbl (
        .mode_i    (mode),
        .rd_addr   (rd_addr),
        .tbl_active(tbl_active),
        .tbl_data  (tbl_data)
    );

    assign prog_stb       = pulse.prog;
    assign sect_erase_stb = pulse.sect;
    assign blk_erase_stb  = pulse.blk;
    assign chip_erase_stb = pulse.chip;
    assign id_enter_stb   = pulse.ident;
    assign cfi_enter_stb  = pulse.query;
    assign mode_exit_stb  = pulse.leave;
    assign mode_o         = mode;

    p_onehot_strobes_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_stb, sect_erase_stb, blk_erase_stb, chip_erase_stb,
                  id_enter_stb, cfi_enter_stb, mode_exit_stb}));

    p_id_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        id_enter_stb |=> (mode_o == 2'd1));

    p_cfi_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfi_enter_stb |=> (mode_o == 2'd2));

    p_abort_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (mode_o == 2'd0));

    p_read_tbl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |-> (!tbl_active && tbl_data == '0));

endmodule

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam int K_NONE = 0, K_PROG = 1, K_SECT = 2, K_BLK = 3,
                   K_CHIP = 4, K_ID = 5, K_CFI = 6, K_EXIT = 7, K_MULTI = 99;

    typedef struct {
        int          kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          prog_stb, sect_erase_stb, blk_erase_stb, chip_erase_stb;
    logic          id_enter_stb, cfi_enter_stb, mode_exit_stb, tbl_active;
    logic [AW-1:0] prog_addr, erase_base;
    logic [DW-1:0] prog_data, tbl_data;
    logic [1:0]    mode_o;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   n_unexp = 0;
    bit   finished = 0;

    always #10 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr),
        .prog_stb(prog_stb), .prog_addr(prog_addr), .prog_data(prog_data),
        .sect_erase_stb(sect_erase_stb), .blk_erase_stb(blk_erase_stb),
        .chip_erase_stb(chip_erase_stb), .erase_base(erase_base),
        .id_enter_stb(id_enter_stb), .cfi_enter_stb(cfi_enter_stb),
        .mode_exit_stb(mode_exit_stb), .mode_o(mode_o),
        .tbl_active(tbl_active), .tbl_data(tbl_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int kind, input logic [AW-1:0] ea,
                      input logic [DW-1:0] ed, input string tag);
        exp_t e;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        if (kind != K_NONE) begin
            e.kind = kind; e.addr = ea; e.data = ed; e.tag = tag;
            exp_q.push_back(e);
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic unlock(input string tag);
        wr(20'h05555, 16'h00AA, K_NONE, '0, '0, tag);
        wr(20'h02AAA, 16'h0055, K_NONE, '0, '0, tag);
    endtask

    task automatic settle_and_drain(input string tag);
        repeat (3) @(negedge clk);
        check({tag, " queue drained"}, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    task automatic look(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        rd_addr = a;
        #1;
        check(tag, 32'(tbl_data), 32'(exp));
    endtask

    // Monitor: compares each observed strobe with the scoreboard head.
    initial begin
        int kind;
        int cnt;
        logic [AW-1:0] oa;
        logic [DW-1:0] od;
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                cnt = $countones({prog_stb, sect_erase_stb, blk_erase_stb, chip_erase_stb,
                                  id_enter_stb, cfi_enter_stb, mode_exit_stb});
                kind = K_NONE; oa = '0; od = '0;
                if (cnt > 1)             kind = K_MULTI;
                else if (prog_stb)       begin kind = K_PROG; oa = prog_addr; od = prog_data; end
                else if (sect_erase_stb) begin kind = K_SECT; oa = erase_base; end
                else if (blk_erase_stb)  begin kind = K_BLK;  oa = erase_base; end
                else if (chip_erase_stb) begin kind = K_CHIP; oa = erase_base; end
                else if (id_enter_stb)   kind = K_ID;
                else if (cfi_enter_stb)  kind = K_CFI;
                else if (mode_exit_stb)  kind = K_EXIT;
                if (kind != K_NONE) begin
                    if (exp_q.size() == 0) begin
                        n_checks++; n_fail++; n_unexp++;
                        $display("FAIL R12 unexpected strobe actual kind %0d expected none", kind);
                    end else begin
                        e = exp_q.pop_front();
                        check({e.tag, " strobe kind"}, 32'(kind), 32'(e.kind));
                        check({e.tag, " strobe addr"}, 32'(oa), 32'(e.addr));
                        check({e.tag, " strobe data"}, 32'(od), 32'(e.data));
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 50000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual running expected done");
        finish_run();
    end

    initial begin
        int unexp_before;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 mode after reset", 32'(mode_o), 32'd0);
        check("R1 strobes after reset",
              32'({prog_stb, sect_erase_stb, blk_erase_stb, chip_erase_stb,
                   id_enter_stb, cfi_enter_stb, mode_exit_stb}), 32'd0);
        check("R1 tbl_active after reset", 32'(tbl_active), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        look("R11 array mode lookup zero", 20'h0, 16'h0000);

        // R2 R3: program with don't-care upper address/data bits on key cycles
        wr(20'hF5555, 16'hABAA, K_NONE, '0, '0, "R2");
        wr(20'h32AAA, 16'h1255, K_NONE, '0, '0, "R2");
        wr(20'h85555, 16'h77A0, K_NONE, '0, '0, "R2");
        wr(20'hABCDE, 16'h1234, K_PROG, 20'hABCDE, 16'h1234, "R3 program");
        settle_and_drain("R3");

        // R3: program word equal to a key value is data, not a key
        unlock("R3");
        wr(20'h05555, 16'h00A0, K_NONE, '0, '0, "R3");
        wr(20'h05555, 16'h00AA, K_PROG, 20'h05555, 16'h00AA, "R3 key-valued program");
        settle_and_drain("R3");

        // R4: chip, sector, block erase
        unlock("R4"); wr(20'h05555, 16'h0080, K_NONE, '0, '0, "R4"); unlock("R4");
        wr(20'h05555, 16'h0010, K_CHIP, 20'h0, 16'h0, "R4 chip erase");
        settle_and_drain("R4");
        unlock("R4"); wr(20'h05555, 16'h0080, K_NONE, '0, '0, "R4"); unlock("R4");
        wr(20'h5A9FF, 16'h0030, K_SECT, 20'h5A800, 16'h0, "R4 sector erase");
        settle_and_drain("R4");
        unlock("R4"); wr(20'h05555, 16'h0080, K_NONE, '0, '0, "R4"); unlock("R4");
        wr(20'h5A9FF, 16'h0050, K_BLK, 20'h58000, 16'h0, "R4 block erase");
        settle_and_drain("R4");

        // R5 R9: identification mode and lookup
        unlock("R5");
        wr(20'h05555, 16'h0090, K_ID, '0, '0, "R5 id entry");
        settle_and_drain("R5");
        check("R5 mode ident", 32'(mode_o), 32'd1);
        check("R9 tbl_active", 32'(tbl_active), 32'd1);
        look("R9 manufacturer word", 20'h0, 16'h00BF);
        look("R9 device word", 20'h1, 16'h2782);
        look("R9 other address", 20'h2, 16'h0000);

        // R8: busy locks out exit and a full program
        unexp_before = n_unexp;
        busy = 1'b1;
        wr(20'h12345, 16'h00F0, K_NONE, '0, '0, "R8");
        unlock("R8");
        wr(20'h05555, 16'h00A0, K_NONE, '0, '0, "R8");
        wr(20'h00100, 16'h5A5A, K_NONE, '0, '0, "R8");
        repeat (3) @(negedge clk);
        check("R8 no strobe while busy", 32'(n_unexp), 32'(unexp_before));
        check("R8 mode held while busy", 32'(mode_o), 32'd1);
        look("R8 lookup held while busy", 20'h0, 16'h00BF);
        busy = 1'b0;
        // sequence progress was not kept: a fresh program still works
        unlock("R8");
        wr(20'h05555, 16'h00A0, K_NONE, '0, '0, "R8");
        wr(20'h00200, 16'hC3C3, K_PROG, 20'h00200, 16'hC3C3, "R8 program after busy");
        settle_and_drain("R8");

        // R6: three-cycle exit
        unlock("R6");
        wr(20'h05555, 16'h00F0, K_EXIT, '0, '0, "R6 keyed exit");
        settle_and_drain("R6");
        check("R6 mode after keyed exit", 32'(mode_o), 32'd0);

        // R5 R10: query mode
        unlock("R5");
        wr(20'h05555, 16'h0098, K_CFI, '0, '0, "R5 query entry");
        settle_and_drain("R5");
        check("R5 mode query", 32'(mode_o), 32'd2);
        look("R10 query Q", 20'h10, 16'h0051);
        look("R10 query R", 20'h11, 16'h0052);
        look("R10 query Y", 20'h12, 16'h0059);
        look("R10 query other", 20'h0, 16'h0000);

        // R6: single-write exit at any address
        wr(20'h12345, 16'h00F0, K_EXIT, '0, '0, "R6 single exit");
        settle_and_drain("R6");
        check("R6 mode after single exit", 32'(mode_o), 32'd0);
        look("R11 array lookup after exit", 20'h10, 16'h0000);

        // R7: abort on wrong second key address, from identification mode
        unlock("R7");
        wr(20'h05555, 16'h0090, K_ID, '0, '0, "R7 id entry");
        settle_and_drain("R7");
        unexp_before = n_unexp;
        wr(20'h05555, 16'h00AA, K_NONE, '0, '0, "R7");
        wr(20'h01234, 16'h0055, K_NONE, '0, '0, "R7");
        wr(20'h05555, 16'h00A0, K_NONE, '0, '0, "R7");
        repeat (3) @(negedge clk);
        check("R7 abort leaves array mode", 32'(mode_o), 32'd0);
        check("R7 no strobe on abort", 32'(n_unexp), 32'(unexp_before));
        unlock("R7");
        wr(20'h05555, 16'h00A0, K_NONE, '0, '0, "R7");
        wr(20'h00300, 16'hBEEF, K_PROG, 20'h00300, 16'hBEEF, "R7 program after abort");
        settle_and_drain("R7");

        // R7: unknown command byte, bad erase selectors
        unexp_before = n_unexp;
        unlock("R7"); wr(20'h05555, 16'h0077, K_NONE, '0, '0, "R7");
        unlock("R7"); wr(20'h05555, 16'h0080, K_NONE, '0, '0, "R7"); unlock("R7");
        wr(20'h05555, 16'h0020, K_NONE, '0, '0, "R7");
        unlock("R7"); wr(20'h05555, 16'h0080, K_NONE, '0, '0, "R7"); unlock("R7");
        wr(20'h01111, 16'h0010, K_NONE, '0, '0, "R7");
        unlock("R7"); wr(20'h05555, 16'h0080, K_NONE, '0, '0, "R7");
        wr(20'h02AAA, 16'h0055, K_NONE, '0, '0, "R7");
        repeat (3) @(negedge clk);
        check("R7 no strobe on bad commands", 32'(n_unexp), 32'(unexp_before));
        unlock("R7"); wr(20'h05555, 16'h0080, K_NONE, '0, '0, "R7"); unlock("R7");
        wr(20'h05555, 16'h0010, K_CHIP, 20'h0, 16'h0, "R7 chip erase after aborts");
        settle_and_drain("R7");

        check("R12 no stray strobes overall", 32'(n_unexp), 32'd0);
        finish_run();
    end

endmodule